// File: doc/BRIEF.md
# Cipher Work/Auxiliary Buffer Datapath

This block keeps the two 128-bit data registers that sit in front of a block-cipher engine. The work buffer holds the engine's input block and receives its output. The auxiliary buffer holds whatever the chaining mode needs next: an initialisation vector, a counter, or the following input block. Software reaches both buffers as 32-bit words on a simple single-cycle register bus. Word 0 covers bits 31:0 of a buffer and the last word covers its top bits.

On top of plain word access, the block has several helpers. A write-only alias XORs the bus data into a work word. A read-only alias returns work XOR auxiliary per word. Clear and abort commands wipe the buffers. A small configuration register selects which accesses to the last word start an encryption, which value loads the work buffer when an encryption starts, and when the auxiliary buffer is folded into the work buffer by hardware.

The engine is external and is driven through a start pulse, the block value it reads, and a done pulse with a result. Word addresses depend on the parameter N (words per buffer, default 4):
- work words: 0..N-1
- XOR alias: N..2N-1
- auxiliary words: 2N..3N-1
- mixed view: 3N..4N-1
- start command: 4N
- clear command: 4N+1
- abort command: 4N+2
- configuration: 4N+3
- status: 4N+4

Top module: `cbuf_datapath`

## Requirements
- R1: After reset every buffer word, the configuration and the status read 0, and `eng_start` and `eng_abort` are low.
- R2: Work and auxiliary words read back what was last written to them. A work-word write is dropped while the engine is busy, but an auxiliary-word write is always taken.
- R3: A write of value d to XOR alias word n sets work word n to d XOR its old value. Such a write is dropped while busy.
- R4: A read of mixed-view word n returns work word n XOR auxiliary word n.
- R5: A write to the start command with bits 1:0 = 01 while idle raises `eng_start` for exactly one cycle after the write edge and sets status bit 0 (busy). The command is ignored while busy and for any other bits 1:0 value.
- R6: Configuration bits 3:0 arm four start triggers: bit 0 a write of the last work word, bit 1 a read of the last work word, bit 2 a write of the last XOR alias word, bit 3 the auxiliary-full flag (R12). Each trigger starts only while idle, and an unarmed access starts nothing.
- R7: When an encryption starts, the work buffer is loaded from the source in configuration bits 5:4: 00 = work, 01 = auxiliary, 10 = work XOR auxiliary (11 keeps the previous setting). That loaded value is the block shown on `eng_block`, with word 0 in bits 31:0.
- R8: `eng_done` while busy writes `eng_result` into the work buffer and clears busy at the same edge. If configuration bit 8 is set, the value written is `eng_result` XOR the auxiliary buffer.
- R9: With configuration bit 9 set, a read of the last work word while idle XORs the auxiliary buffer into the work buffer at that edge.
- R10: A clear command write while idle zeroes the work buffer when bit 1 is set and the auxiliary buffer when bit 0 is set. While busy, the command leaves both buffers unchanged.
- R11: An abort command write with bit 0 set zeroes both buffers, the configuration and the full flag, returns the engine to idle, and pulses `eng_abort` for one cycle.
- R12: With trigger bit 3 armed, a write of the last auxiliary word sets a full flag, shown as status bit 1. Status bit 1 reads 0 when bit 3 is not armed. While the flag is set and the engine is idle, an encryption starts at the next edge and consumes the flag, so a flag set during a busy phase starts one cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, combinational from address |
| eng_start | output | 1 | One-cycle encryption start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_block | output | N*WORD_W | Block presented to the engine (work buffer) |
| eng_done | input | 1 | Engine finished; result valid |
| eng_result | input | N*WORD_W | Engine output block |

## Verification
Read data is combinational, so a read is sampled in the same cycle as its address, before the edge that would apply any read side effect. Buffer writes, clears, aborts and the done write-back all land at the edge that takes the access, so the bench reads them back in the next access. `eng_start` and `eng_abort` are registered and are checked at the falling edge right after the accepting edge. For a full flag pending during a busy phase, the start comes one edge later than the done edge, and the bench samples status between those two edges and `eng_start` after the second.

// File: rtl/cbuf_pkg.sv
// Shared types and encodings for the cipher buffer datapath.
// Assumes configuration fields sit in the low ten bits of a bus word.
package cbuf_pkg;

    typedef enum logic [1:0] {
        SRC_WORK = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_MIX  = 2'd2
    } src_e;

    typedef struct packed {
        logic [1:0] autoxor;   // bit0: fold aux into result, bit1: fold on last-word read
        src_e       src;       // start source
        logic [3:0] trig;      // start triggers
    } cfg_t;

    localparam int TRIG_WR_WORK = 0;
    localparam int TRIG_RD_WORK = 1;
    localparam int TRIG_WR_XOR  = 2;
    localparam int TRIG_WR_AUX  = 3;

    localparam logic [1:0] OP_ENCRYPT = 2'b01;

    typedef struct packed {
        logic work;
        logic xalias;
        logic aux;
        logic mix;
        logic start;
        logic clear;
        logic abort;
        logic cfg;
        logic status;
    } sel_t;

    // Decode a configuration write; an unlisted source code keeps the old one.
    function automatic cfg_t cfg_from_bits(input logic [9:0] b, input cfg_t old);
        cfg_t c;
        c.trig    = b[3:0];
        c.src     = (b[5:4] == 2'b11) ? old.src : src_e'(b[5:4]);
        c.autoxor = b[9:8];
        return c;
    endfunction

    // Encode configuration as a bus word.
    function automatic logic [31:0] cfg_to_word(input cfg_t c);
        return {22'd0, c.autoxor, 2'b00, c.src, c.trig};
    endfunction

endpackage

// File: rtl/cbuf_decode.sv
// Address decoder: splits a word address into a region select and a word index.
// Assumes one access per cycle and ADDR_W wide enough for 4*NWORDS+5 words.
module cbuf_decode #(
    parameter int NWORDS = 4,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]                         bus_addr,
    output cbuf_pkg::sel_t                            sel,
    output logic [((NWORDS > 1) ? $clog2(NWORDS) : 1)-1:0] idx,
    output logic                                      last
);
    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam logic [31:0] NW32 = 32'(NWORDS);
    localparam logic [31:0] CTRL = 32'(4 * NWORDS);

    logic [31:0] addr32;
    logic [31:0] region;

    // Region and index from the address.
    always_comb begin
        addr32     = 32'(bus_addr);
        region     = addr32 / NW32;
        idx        = IDX_W'(addr32 % NW32);
        last       = (idx == IDX_W'(NWORDS - 1));
        sel        = '0;
        sel.work   = (region == 32'd0);
        sel.xalias = (region == 32'd1);
        sel.aux    = (region == 32'd2);
        sel.mix    = (region == 32'd3);
        sel.start  = (addr32 == CTRL);
        sel.clear  = (addr32 == CTRL + 32'd1);
        sel.abort  = (addr32 == CTRL + 32'd2);
        sel.cfg    = (addr32 == CTRL + 32'd3);
        sel.status = (addr32 == CTRL + 32'd4);
    end
endmodule

// File: rtl/cbuf_ctrl.sv
// Control: busy state, auxiliary-full flag, configuration, start and abort decisions.
// Assumes the engine answers each start with exactly one done unless aborted.
module cbuf_ctrl (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  cbuf_pkg::sel_t  sel,
    input  logic            last,
    input  logic [9:0]      cmd_bits,
    input  logic            eng_done,
    output cbuf_pkg::cfg_t  cfg,
    output logic            busy,
    output logic            full,
    output logic            start_go,
    output logic            abort_go,
    output logic            done_go,
    output logic            clr_work,
    output logic            clr_aux,
    output logic            rdxor_go,
    output logic            we_work,
    output logic            we_xor,
    output logic            we_aux,
    output logic            eng_start,
    output logic            eng_abort
);
    import cbuf_pkg::*;

    logic idle, ok;
    logic wr_w_last, rd_w_last, wr_x_last, wr_a_last;
    logic full_nx, manual, trig_go;

    // Access classification and command acceptance.
    always_comb begin
        abort_go  = bus_wr && sel.abort && cmd_bits[0];
        idle      = !busy;
        ok        = idle && !abort_go;
        we_work   = bus_wr && sel.work && idle;
        we_xor    = bus_wr && sel.xalias && idle;
        we_aux    = bus_wr && sel.aux;
        wr_w_last = we_work && last;
        rd_w_last = bus_rd && sel.work && last;
        wr_x_last = we_xor && last;
        wr_a_last = we_aux && last;
        full_nx   = full || (wr_a_last && cfg.trig[TRIG_WR_AUX]);
        manual    = bus_wr && sel.start && (cmd_bits[1:0] == OP_ENCRYPT);
        trig_go   = (cfg.trig[TRIG_WR_WORK] && wr_w_last)
                 || (cfg.trig[TRIG_RD_WORK] && rd_w_last)
                 || (cfg.trig[TRIG_WR_XOR]  && wr_x_last)
                 || (cfg.trig[TRIG_WR_AUX]  && full_nx);
        start_go  = ok && (manual || trig_go);
        done_go   = busy && eng_done && !abort_go;
        clr_work  = ok && bus_wr && sel.clear && cmd_bits[1];
        clr_aux   = ok && bus_wr && sel.clear && cmd_bits[0];
        rdxor_go  = ok && rd_w_last && cfg.autoxor[1];
    end

    // Engine busy state.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_go)  busy <= 1'b0;
        else if (start_go)       busy <= 1'b1;
        else if (done_go)        busy <= 1'b0;
    end

    // Auxiliary-full flag: set by last-word write, consumed by a start.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_go)         full <= 1'b0;
        else if (start_go || clr_aux)   full <= 1'b0;
        else                            full <= full_nx;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_go)       cfg <= '0;
        else if (bus_wr && sel.cfg)   cfg <= cfg_from_bits(cmd_bits, cfg);
    end

    // Registered pulses towards the engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            eng_abort <= 1'b0;
        end else begin
            eng_start <= start_go;
            eng_abort <= abort_go;
        end
    end
endmodule

// File: rtl/cbuf_store.sv
// Storage for the work and auxiliary buffers with their word-level update paths.
// Assumes control has already gated every write enable by the engine state.
module cbuf_store #(
    parameter int NWORDS = 4,
    parameter int WORD_W = 32
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic [((NWORDS > 1) ? $clog2(NWORDS) : 1)-1:0] idx,
    input  logic [WORD_W-1:0]                            wdata,
    input  logic                                         we_work,
    input  logic                                         we_xor,
    input  logic                                         we_aux,
    input  logic                                         rdxor_go,
    input  logic                                         start_go,
    input  cbuf_pkg::src_e                               src,
    input  logic                                         abort_go,
    input  logic                                         clr_work,
    input  logic                                         clr_aux,
    input  logic                                         done_go,
    input  logic                                         done_xor,
    input  logic [NWORDS*WORD_W-1:0]                     result,
    output logic [NWORDS-1:0][WORD_W-1:0]                work,
    output logic [NWORDS-1:0][WORD_W-1:0]                aux
);
    import cbuf_pkg::*;

    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int BLK_W = NWORDS * WORD_W;

    logic [NWORDS-1:0][WORD_W-1:0] work_nx, aux_nx;
    logic [BLK_W-1:0]              src_val, done_val;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        logic [WORD_W-1:0] w_n, a_n;
        logic              hit;
        // Per-word next value after this cycle's bus access.
        always_comb begin
            hit = (idx == IDX_W'(i));
            a_n = (we_aux && hit) ? wdata : aux[i];
            w_n = work[i];
            if (we_work && hit) w_n = wdata;
            if (we_xor && hit)  w_n = wdata ^ work[i];
            if (rdxor_go)       w_n = w_n ^ aux[i];
        end
        assign work_nx[i] = w_n;
        assign aux_nx[i]  = a_n;
    end

    // Start source and done write-back values.
    always_comb begin
        case (src)
            SRC_AUX: src_val = aux_nx;
            SRC_MIX: src_val = work_nx ^ aux_nx;
            default: src_val = work_nx;
        endcase
        done_val = done_xor ? (result ^ aux) : result;
    end

    // Work buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_go) work <= '0;
        else if (done_go)       work <= done_val;
        else if (start_go)      work <= src_val;
        else if (clr_work)      work <= '0;
        else                    work <= work_nx;
    end

    // Auxiliary buffer update.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_go || clr_aux) aux <= '0;
        else                               aux <= aux_nx;
    end
endmodule

// File: rtl/cbuf_datapath.sv
// Top of the cipher buffer datapath: decode, control, storage and read mux.
// Assumes a single-cycle register bus and an external engine with start/done.
module cbuf_datapath #(
    parameter int NWORDS = 4,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    output logic                     eng_start,
    output logic                     eng_abort,
    output logic [NWORDS*WORD_W-1:0] eng_block,
    input  logic                     eng_done,
    input  logic [NWORDS*WORD_W-1:0] eng_result
);
    import cbuf_pkg::*;

    localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int BLK_W = NWORDS * WORD_W;

    sel_t                          sel;
    logic [IDX_W-1:0]              idx;
    logic                          last;
    cfg_t                          cfg;
    logic                          busy, full;
    logic                          start_go, abort_go, done_go;
    logic                          clr_work, clr_aux, rdxor_go;
    logic                          we_work, we_xor, we_aux;
    logic [NWORDS-1:0][WORD_W-1:0] work, aux;
    logic [BLK_W-1:0]              work_flat;

    cbuf_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
        .bus_addr (bus_addr),
        .sel      (sel),
        .idx      (idx),
        .last     (last)
    );

    cbuf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .sel       (sel),
        .last      (last),
        .cmd_bits  (bus_wdata[9:0]),
        .eng_done  (eng_done),
        .cfg       (cfg),
        .busy      (busy),
        .full      (full),
        .start_go  (start_go),
        .abort_go  (abort_go),
        .done_go   (done_go),
        .clr_work  (clr_work),
        .clr_aux   (clr_aux),
        .rdxor_go  (rdxor_go),
        .we_work   (we_work),
        .we_xor    (we_xor),
        .we_aux    (we_aux),
        .eng_start (eng_start),
        .eng_abort (eng_abort)
    );

    cbuf_store #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (idx),
        .wdata    (bus_wdata),
        .we_work  (we_work),
        .we_xor   (we_xor),
        .we_aux   (we_aux),
        .rdxor_go (rdxor_go),
        .start_go (start_go),
        .src      (cfg.src),
        .abort_go (abort_go),
        .clr_work (clr_work),
        .clr_aux  (clr_aux),
        .done_go  (done_go),
        .done_xor (cfg.autoxor[0]),
        .result   (eng_result),
        .work     (work),
        .aux      (aux)
    );

    assign work_flat = work;
    assign eng_block = work_flat;

    // Read data multiplexer; write-only and command addresses read 0.
    always_comb begin
        bus_rdata = '0;
        if (sel.work)        bus_rdata = work[idx];
        else if (sel.aux)    bus_rdata = aux[idx];
        else if (sel.mix)    bus_rdata = work[idx] ^ aux[idx];
        else if (sel.cfg)    bus_rdata = WORD_W'(cfg_to_word(cfg));
        else if (sel.status) bus_rdata = WORD_W'({full && cfg.trig[TRIG_WR_AUX], busy});
        else if (sel.xalias || sel.start || sel.clear || sel.abort) bus_rdata = '0;
    end
endmodule

// File: rtl/cbuf_chk.sv
// Temporal checks on the datapath, attached to the top by bind.
module cbuf_chk #(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_start,
    input logic             eng_abort,
    input logic             eng_done,
    input logic             busy,
    input logic [BLK_W-1:0] work
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R5
    AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) eng_start |-> busy); // R5
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) eng_abort |-> !busy); // R11
    AST_WORK_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(work)); // R2
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (busy && eng_done) |=> !busy); // R8
endmodule

bind cbuf_datapath cbuf_chk #(.BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .eng_done  (eng_done),
    .busy      (busy),
    .work      (work_flat)
);

// File: tb/sim_cbuf_datapath.sv
module sim_cbuf_datapath;
    localparam logic [4:0] A_W0 = 5'd0, A_W1 = 5'd1, A_W2 = 5'd2, A_W3 = 5'd3;
    localparam logic [4:0] A_X1 = 5'd5, A_X3 = 5'd7;
    localparam logic [4:0] A_A0 = 5'd8, A_A1 = 5'd9, A_A3 = 5'd11;
    localparam logic [4:0] A_START = 5'd16, A_CLEAR = 5'd17, A_ABORT = 5'd18;
    localparam logic [4:0] A_CFG = 5'd19, A_STAT = 5'd20;

    localparam logic [127:0] P    = 128'h44444444_33333333_22222222_11111111;
    localparam logic [127:0] Q    = 128'hA0A0A0A3_A0A0A0A2_A0A0A0A1_A0A0A0A0;
    localparam logic [127:0] RES1 = 128'hCAFE0003_CAFE0002_CAFE0001_CAFE0000;

    typedef struct packed {
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic [4:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  32'h11111111, 5'd0,  32'h11111111},
        '{5'd3,  32'hA5A5A5A5, 5'd3,  32'hA5A5A5A5},
        '{5'd8,  32'h0F0F0F0F, 5'd8,  32'h0F0F0F0F},
        '{5'd4,  32'h000000FF, 5'd0,  32'h111111EE},
        '{5'd7,  32'hFFFF0000, 5'd3,  32'h5A5AA5A5},
        '{5'd11, 32'h0000FFFF, 5'd15, 32'h5A5A5A5A},
        '{5'd9,  32'h12345678, 5'd13, 32'h12345678},
        '{5'd1,  32'h12345678, 5'd13, 32'h00000000},
        '{5'd10, 32'h00000000, 5'd12, 32'h1E1E1EE1}
    };
    localparam string VTAG [NV] = '{"R2", "R2", "R2", "R3", "R3", "R4", "R4", "R4", "R4"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_start, eng_abort;
    logic [127:0] eng_block;
    logic         eng_done = 1'b0;
    logic [127:0] eng_result = '0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cbuf_datapath u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_block(eng_block),
        .eng_done(eng_done), .eng_result(eng_result)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, 128'(v), 128'(exp));
    endtask

    task automatic finish_eng(input logic [127:0] res);
        @(negedge clk);
        eng_done = 1'b1; eng_result = res;
        @(posedge clk); #1;
        eng_done = 1'b0;
    endtask

    task automatic load_work(input logic [127:0] v);
        for (int i = 0; i < 4; i++) wr(5'(i), v[i*32 +: 32]);
    endtask

    task automatic load_aux(input logic [127:0] v);
        for (int i = 0; i < 4; i++) wr(5'(8 + i), v[i*32 +: 32]);
    endtask

    task automatic start_seen(input string tag, input logic exp);
        @(negedge clk);
        chk(tag, 128'(eng_start), 128'(exp));
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 eng_start", 128'(eng_start), 128'd0);
        chk("R1 eng_abort", 128'(eng_abort), 128'd0);
        rdchk("R1 work0", A_W0, 32'h0);
        rdchk("R1 aux3", A_A3, 32'h0);
        rdchk("R1 cfg", A_CFG, 32'h0);
        rdchk("R1 status", A_STAT, 32'h0);

        // Table walk: word writes, XOR alias, mixed view
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].waddr, VEC[i].wdata);
            rdchk(VTAG[i], VEC[i].raddr, VEC[i].exp);
        end

        // R11 abort wipes buffers
        wr(A_ABORT, 32'h1);
        @(negedge clk);
        chk("R11 abort pulse", 128'(eng_abort), 128'd1);
        rdchk("R11 work0 zero", A_W0, 32'h0);

        // R5 manual start, R2/R3/R10 behaviour while busy, R8 done
        load_work(P);
        wr(A_START, 32'h1);
        start_seen("R5 start pulse", 1'b1);
        chk("R7 block from work", eng_block, P);
        start_seen("R5 pulse one cycle", 1'b0);
        rdchk("R5 busy status", A_STAT, 32'h1);
        wr(A_W0, 32'hDEADBEEF);
        wr(A_X1, 32'hFFFFFFFF);
        rdchk("R2 work write blocked", A_W0, 32'h11111111);
        rdchk("R3 xor blocked", A_W1, 32'h22222222);
        wr(A_A0, 32'h00000055);
        rdchk("R2 aux write while busy", A_A0, 32'h55);
        wr(A_START, 32'h1);
        start_seen("R5 start ignored busy", 1'b0);
        wr(A_CLEAR, 32'h3);
        rdchk("R10 clear blocked work", A_W2, 32'h33333333);
        rdchk("R10 clear blocked aux", A_A0, 32'h55);
        finish_eng(RES1);
        rdchk("R8 idle after done", A_STAT, 32'h0);
        rdchk("R8 result word0", A_W0, 32'hCAFE0000);
        rdchk("R8 result word3", A_W3, 32'hCAFE0003);
        wr(A_START, 32'h2);
        start_seen("R5 bad opcode", 1'b0);

        // R10 clear while idle
        wr(A_CLEAR, 32'h1);
        rdchk("R10 aux cleared", A_A0, 32'h0);
        rdchk("R10 work kept", A_W0, 32'hCAFE0000);
        wr(A_CLEAR, 32'h2);
        rdchk("R10 work cleared", A_W0, 32'h0);

        // R7 start sources
        load_aux(Q);
        load_work(P);
        wr(A_CFG, 32'h10);
        wr(A_START, 32'h1);
        start_seen("R7 start aux", 1'b1);
        chk("R7 block from aux", eng_block, Q);
        finish_eng(RES1);
        wr(A_CFG, 32'h20);
        wr(A_START, 32'h1);
        start_seen("R7 start mix", 1'b1);
        chk("R7 block from mix", eng_block, RES1 ^ Q);

        // R11 abort while busy
        wr(A_ABORT, 32'h1);
        @(negedge clk);
        chk("R11 abort pulse busy", 128'(eng_abort), 128'd1);
        rdchk("R11 idle", A_STAT, 32'h0);
        rdchk("R11 work zero", A_W0, 32'h0);
        rdchk("R11 aux zero", A_A1, 32'h0);
        rdchk("R11 cfg zero", A_CFG, 32'h0);

        // R6 triggers
        load_work(P);
        wr(A_CFG, 32'h1);
        wr(A_W3, 32'h44444444);
        start_seen("R6 write-last trigger", 1'b1);
        finish_eng(RES1);
        wr(A_CFG, 32'h2);
        rdchk("R6 read-last data", A_W3, 32'hCAFE0003);
        @(negedge clk);
        chk("R6 read-last trigger", 128'(eng_start), 128'd1);
        finish_eng(RES1);
        wr(A_CFG, 32'h4);
        wr(A_X3, 32'h0);
        start_seen("R6 xor-last trigger", 1'b1);
        finish_eng(RES1);
        wr(A_CFG, 32'h0);
        wr(A_W3, 32'h1);
        start_seen("R6 unarmed write", 1'b0);
        wr(A_X3, 32'h1);
        start_seen("R6 unarmed xor", 1'b0);

        // R8 fold aux into result
        load_aux(Q);
        wr(A_CFG, 32'h100);
        wr(A_START, 32'h1);
        finish_eng(RES1);
        rdchk("R8 folded result", A_W0, 32'h6A5EA0A0);

        // R9 fold on last-word read
        wr(A_CFG, 32'h200);
        rdchk("R9 read before fold", A_W3, 32'h6A5EA0A0);
        rdchk("R9 folded work0", A_W0, 32'hCAFE0000);

        // R12 full flag
        wr(A_CFG, 32'h0);
        wr(A_A3, 32'h55);
        rdchk("R12 masked unarmed", A_STAT, 32'h0);
        wr(A_CFG, 32'h8);
        rdchk("R12 no flag yet", A_STAT, 32'h0);
        wr(A_START, 32'h1);
        load_aux(Q);
        rdchk("R12 full while busy", A_STAT, 32'h3);
        finish_eng(RES1);
        rdchk("R12 full pending", A_STAT, 32'h2);
        @(negedge clk);
        chk("R12 pending start", 128'(eng_start), 128'd1);
        chk("R12 block is result", eng_block, RES1);
        rdchk("R12 consumed", A_STAT, 32'h1);
        finish_eng(RES1);
        wr(A_A3, 32'h1);
        start_seen("R12 idle immediate start", 1'b1);
        finish_eng(RES1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule